// File: doc/BRIEF.md
# Card Host Controller Register Bank

This block is the 16-bit control and status register bank of a memory-card host controller. Software programs it over a simple synchronous register bus: the command argument, bus configuration, transfer lengths, FIFO thresholds with DMA enables, and the command and data timeouts. A write to the command register hands a decoded command to the command engine as a one-cycle pulse. The configuration fields drive the rest of the controller directly through dedicated output ports.

Two hardware events set status bits. A rising edge on the card-detect line sets the insertion bit. Completion of the last byte of the last programmed block sets the transfer-done bit. The data path reports each byte it moves through a strobe. That strobe steps a live byte counter and a live block counter, and software reads both counters back at the length registers. The status bits are cleared by writing a one to them. They are masked into a single level interrupt.

Card detection uses a two-state machine. `CD_ABSENT` moves to `CD_PRESENT` when the card-detect input is high, and this transition produces the insertion event. `CD_PRESENT` returns to `CD_ABSENT` when the input is low. `CD_ABSENT` stays put while the input is low, and `CD_PRESENT` stays put while it is high. The card-detect input is taken to be synchronous to `clk`.

Top module: `card_host_regs`

## Requirements
- R1: After reset, every register reads zero except the FIFO-threshold register, which reads 0x1F00 (almost-full level 31). The interrupt is low.
- R2: `irq` is high exactly when (status AND interrupt-enable) is nonzero. The interrupt-enable register sits at offset 0x14 and keeps 15 bits; write-data bit 15 is dropped and reads back as 0.
- R3: A write to status (offset 0x10) clears each bit written as 1 and leaves bits written as 0 unchanged. A hardware set in the same cycle as a clear wins.
- R4: The 32-bit argument `cmd_arg` is written as its low half at 0x04 and its high half at 0x08. Each write changes only its own half, and each half reads back at its offset.
- R5: A write to offset 0x00 raises `cmd_valid` for exactly the one cycle after the write. It presents index = bits 5:0, response type = bits 10:8, kind = bits 13:12 and direction = bit 15. The register reads back the written value ANDed with 0xB73F.
- R6: The configuration register (0x0C) drives wide-bus from bit 15, mode from bits 13:12, enable from bit 11, big-endian from bit 10 and clock divider from bits 9:0. It reads back the written value ANDed with 0xBFFF.
- R7: The FIFO-threshold register (0x2C) drives receive-DMA enable from bit 15, almost-full level from bits 12:8, transmit-DMA enable from bit 7 and almost-empty level from bits 4:0. It reads back the written value ANDed with 0x9F9F.
- R8: The command timeout (0x18) keeps 8 bits and the data timeout (0x1C) keeps 16 bits. Each drives its output and reads back its kept bits.
- R9: Writing v to block length (0x24) or block count (0x28) stores (v[10:0] + 1) and loads the matching live counter. A block-count write also reloads the byte counter with the block length. Offsets 0x24 and 0x28 read back the live byte and block counters.
- R10: Each `xfer_byte` strobe, while both counters are nonzero, decrements the byte counter. On a byte count of 1 the byte counter instead reloads the block length and the block counter steps down. On a block count of 1 the block counter reloads the block count and status bit 3 is set.
- R11: A low-to-high change of `card_det`, or `card_det` high in the first cycle after reset, sets status bit 1 once. Holding the line high does not set the bit again.
- R12: A write to offset 0x64 with bit 2 set returns every register and counter to its R1 value and leaves the card-detect state unchanged. A write there with bit 2 clear has no effect.
- R13: `bus_rdata` shows the register addressed on the cycle after `bus_re` and holds between reads. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, one cycle after `bus_re` |
| card_det | input | 1 | Card-detect level |
| xfer_byte | input | 1 | One byte moved by the data path |
| irq | output | 1 | Level interrupt |
| cmd_valid | output | 1 | Command-issue pulse |
| cmd_index | output | 6 | Command index |
| cmd_rsp_type | output | 3 | Response type |
| cmd_kind | output | 2 | Command kind |
| cmd_dir | output | 1 | Data direction |
| cmd_arg | output | 32 | Command argument |
| cfg_wide_bus | output | 1 | Four-line data bus |
| cfg_mode | output | 2 | Operating mode |
| cfg_enable | output | 1 | Controller enable |
| cfg_big_endian | output | 1 | Byte order select |
| cfg_clk_div | output | 10 | Card clock divider |
| rx_dma_en | output | 1 | Receive DMA enable |
| tx_dma_en | output | 1 | Transmit DMA enable |
| fifo_af_level | output | 5 | Almost-full threshold |
| fifo_ae_level | output | 5 | Almost-empty threshold |
| cmd_timeout | output | 8 | Command timeout |
| data_timeout | output | 16 | Data timeout |

## Verification
A corrupted field register shows up on its dedicated output port the cycle after the write. It also shows up on `bus_rdata` one cycle after the next read, so the field sweeps catch a wrong bit position at once. A wrong count in the length counters appears at the next read of 0x24 or 0x28 after a strobe. A missed or doubled block rollover appears as transfer-done set at the wrong byte. A card-detect machine stuck in the wrong state either never sets status bit 1 or sets it again while the line stays high. The test sees this in the status read that follows the edge.

// File: rtl/chr_pkg.sv
package chr_pkg;
    localparam int unsigned REG_W = 16;

    localparam int unsigned OFF_CMD    = 'h00;
    localparam int unsigned OFF_ARG_LO = 'h04;
    localparam int unsigned OFF_ARG_HI = 'h08;
    localparam int unsigned OFF_CFG    = 'h0C;
    localparam int unsigned OFF_STAT   = 'h10;
    localparam int unsigned OFF_IEN    = 'h14;
    localparam int unsigned OFF_CTO    = 'h18;
    localparam int unsigned OFF_DTO    = 'h1C;
    localparam int unsigned OFF_BLEN   = 'h24;
    localparam int unsigned OFF_NBLK   = 'h28;
    localparam int unsigned OFF_FIFO   = 'h2C;
    localparam int unsigned OFF_SYSCTL = 'h64;

    localparam int unsigned ST_CARD_IN   = 1;
    localparam int unsigned ST_XFER_DONE = 3;
    localparam int unsigned SOFT_RST_BIT = 2;

    typedef enum logic {
        CD_ABSENT  = 1'b0,
        CD_PRESENT = 1'b1
    } cd_state_e;

    typedef struct packed {
        logic       dir;
        logic [1:0] kind;
        logic [2:0] rsp;
        logic [5:0] idx;
    } cmd_fields_t;
endpackage

// File: rtl/chr_cd_fsm.sv
module chr_cd_fsm
    import chr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cd_in,
    output logic ins_event
);
    cd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CD_ABSENT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        ins_event = 1'b0;
        unique case (state_q)
            CD_ABSENT: if (cd_in) begin
                state_d   = CD_PRESENT;
                ins_event = 1'b1;
            end
            CD_PRESENT: if (!cd_in) state_d = CD_ABSENT;
        endcase
    end

    // R11: an insertion is reported once per rising level
    p_insert_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ins_event |=> !ins_event);
endmodule

// File: rtl/chr_len_ctr.sv
module chr_len_ctr #(
    parameter int unsigned LEN_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           soft_rst,
    input  logic           blen_we,
    input  logic           nblk_we,
    input  logic [LEN_W-1:0] wval,
    input  logic           xfer_byte,
    output logic [LEN_W:0] byte_ctr,
    output logic [LEN_W:0] blk_ctr,
    output logic           done_evt
);
    localparam int unsigned CW = LEN_W + 1;

    logic [CW-1:0] blen_cfg, nblk_cfg, wplus1;
    logic          stepping;

    assign wplus1   = {1'b0, wval} + CW'(1);
    assign stepping = xfer_byte && !blen_we && !nblk_we
                      && (byte_ctr != '0) && (blk_ctr != '0);
    assign done_evt = stepping && (byte_ctr == CW'(1)) && (blk_ctr == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            blen_cfg <= '0;
            nblk_cfg <= '0;
            byte_ctr <= '0;
            blk_ctr  <= '0;
        end else if (blen_we) begin
            blen_cfg <= wplus1;
            byte_ctr <= wplus1;
        end else if (nblk_we) begin
            nblk_cfg <= wplus1;
            blk_ctr  <= wplus1;
            byte_ctr <= blen_cfg;
        end else if (stepping) begin
            if (byte_ctr == CW'(1)) begin
                byte_ctr <= blen_cfg;
                blk_ctr  <= (blk_ctr == CW'(1)) ? nblk_cfg : blk_ctr - CW'(1);
            end else begin
                byte_ctr <= byte_ctr - CW'(1);
            end
        end
    end

    // R9: the live byte counter never exceeds the programmed length
    p_byte_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ctr <= blen_cfg);
    // R10: finishing the last block reloads the block counter
    p_block_reload_r10: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        done_evt |=> (blk_ctr == $past(nblk_cfg)) && (byte_ctr == $past(blen_cfg)));
endmodule

// File: rtl/chr_status.sv
module chr_status #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    input  logic [W-2:0] ien,
    output logic [W-1:0] status,
    output logic         irq
);
    logic [W-1:0] clr_vec;

    assign clr_vec = clr_we ? clr_data : '0;
    assign irq     = |(status & {1'b0, ien});

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) status <= '0;
        else                    status <= (status & ~clr_vec) | set_vec;
    end

    // R3: cleared bits drop unless hardware sets them in the same cycle
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (status & $past(clr_data & ~set_vec)) == '0);
    // R3: a hardware set always lands
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (set_vec != '0) |=> (status & $past(set_vec)) == $past(set_vec));
endmodule

// File: rtl/card_host_regs.sv
module card_host_regs
    import chr_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_re,
    output logic [15:0]       bus_rdata,
    input  logic              card_det,
    input  logic              xfer_byte,
    output logic              irq,
    output logic              cmd_valid,
    output logic [5:0]        cmd_index,
    output logic [2:0]        cmd_rsp_type,
    output logic [1:0]        cmd_kind,
    output logic              cmd_dir,
    output logic [31:0]       cmd_arg,
    output logic              cfg_wide_bus,
    output logic [1:0]        cfg_mode,
    output logic              cfg_enable,
    output logic              cfg_big_endian,
    output logic [9:0]        cfg_clk_div,
    output logic              rx_dma_en,
    output logic              tx_dma_en,
    output logic [4:0]        fifo_af_level,
    output logic [4:0]        fifo_ae_level,
    output logic [7:0]        cmd_timeout,
    output logic [15:0]       data_timeout
);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_ARGL = ADDR_W'(OFF_ARG_LO);
    localparam logic [ADDR_W-1:0] A_ARGH = ADDR_W'(OFF_ARG_HI);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN);
    localparam logic [ADDR_W-1:0] A_CTO  = ADDR_W'(OFF_CTO);
    localparam logic [ADDR_W-1:0] A_DTO  = ADDR_W'(OFF_DTO);
    localparam logic [ADDR_W-1:0] A_BLEN = ADDR_W'(OFF_BLEN);
    localparam logic [ADDR_W-1:0] A_NBLK = ADDR_W'(OFF_NBLK);
    localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(OFF_FIFO);
    localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(OFF_SYSCTL);
    localparam logic [15:0] CMD_KEEP = 16'hB73F;
    localparam logic [15:0] CFG_KEEP = 16'hBFFF;
    localparam logic [15:0] BUF_KEEP = 16'h9F9F;

    logic              wr_cmd, wr_argl, wr_argh, wr_cfg, wr_stat, wr_ien;
    logic              wr_cto, wr_dto, wr_blen, wr_nblk, wr_fifo, soft_rst;
    logic [15:0]       cmd_q, cfg_q, fifo_q, status, rd_mux;
    logic [14:0]       ien_q;
    logic [LEN_W:0]    byte_ctr, blk_ctr;
    logic              ins_event, done_evt;
    logic [15:0]       set_vec;
    cmd_fields_t       cmd_f;

    assign wr_cmd   = bus_we && bus_addr == A_CMD;
    assign wr_argl  = bus_we && bus_addr == A_ARGL;
    assign wr_argh  = bus_we && bus_addr == A_ARGH;
    assign wr_cfg   = bus_we && bus_addr == A_CFG;
    assign wr_stat  = bus_we && bus_addr == A_STAT;
    assign wr_ien   = bus_we && bus_addr == A_IEN;
    assign wr_cto   = bus_we && bus_addr == A_CTO;
    assign wr_dto   = bus_we && bus_addr == A_DTO;
    assign wr_blen  = bus_we && bus_addr == A_BLEN;
    assign wr_nblk  = bus_we && bus_addr == A_NBLK;
    assign wr_fifo  = bus_we && bus_addr == A_FIFO;
    assign soft_rst = bus_we && bus_addr == A_SYS && bus_wdata[SOFT_RST_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cmd_q        <= '0;
            cmd_valid    <= 1'b0;
            cmd_arg      <= '0;
            cfg_q        <= '0;
            ien_q        <= '0;
            cmd_timeout  <= '0;
            data_timeout <= '0;
            fifo_q       <= 16'h1F00;
        end else begin
            cmd_valid <= wr_cmd;
            if (wr_cmd)  cmd_q         <= bus_wdata & CMD_KEEP;
            if (wr_argl) cmd_arg[15:0]  <= bus_wdata;
            if (wr_argh) cmd_arg[31:16] <= bus_wdata;
            if (wr_cfg)  cfg_q         <= bus_wdata & CFG_KEEP;
            if (wr_ien)  ien_q         <= bus_wdata[14:0];
            if (wr_cto)  cmd_timeout   <= bus_wdata[7:0];
            if (wr_dto)  data_timeout  <= bus_wdata;
            if (wr_fifo) fifo_q        <= bus_wdata & BUF_KEEP;
        end
    end

    assign cmd_f          = {cmd_q[15], cmd_q[13:12], cmd_q[10:8], cmd_q[5:0]};
    assign cmd_dir        = cmd_f.dir;
    assign cmd_kind       = cmd_f.kind;
    assign cmd_rsp_type   = cmd_f.rsp;
    assign cmd_index      = cmd_f.idx;
    assign cfg_wide_bus   = cfg_q[15];
    assign cfg_mode       = cfg_q[13:12];
    assign cfg_enable     = cfg_q[11];
    assign cfg_big_endian = cfg_q[10];
    assign cfg_clk_div    = cfg_q[9:0];
    assign rx_dma_en      = fifo_q[15];
    assign fifo_af_level  = fifo_q[12:8];
    assign tx_dma_en      = fifo_q[7];
    assign fifo_ae_level  = fifo_q[4:0];

    always_comb begin
        set_vec               = '0;
        set_vec[ST_CARD_IN]   = ins_event;
        set_vec[ST_XFER_DONE] = done_evt;
    end

    chr_cd_fsm u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cd_in     (card_det),
        .ins_event (ins_event)
    );

    chr_len_ctr #(.LEN_W(LEN_W)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .blen_we   (wr_blen),
        .nblk_we   (wr_nblk),
        .wval      (bus_wdata[LEN_W-1:0]),
        .xfer_byte (xfer_byte),
        .byte_ctr  (byte_ctr),
        .blk_ctr   (blk_ctr),
        .done_evt  (done_evt)
    );

    chr_status #(.W(16)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .set_vec  (set_vec),
        .clr_we   (wr_stat),
        .clr_data (bus_wdata),
        .ien      (ien_q),
        .status   (status),
        .irq      (irq)
    );

    always_comb begin
        rd_mux = '0;
        unique case (1'b1)
            bus_addr == A_CMD:  rd_mux = cmd_q;
            bus_addr == A_ARGL: rd_mux = cmd_arg[15:0];
            bus_addr == A_ARGH: rd_mux = cmd_arg[31:16];
            bus_addr == A_CFG:  rd_mux = cfg_q;
            bus_addr == A_STAT: rd_mux = status;
            bus_addr == A_IEN:  rd_mux = {1'b0, ien_q};
            bus_addr == A_CTO:  rd_mux = {8'h00, cmd_timeout};
            bus_addr == A_DTO:  rd_mux = data_timeout;
            bus_addr == A_BLEN: rd_mux = 16'(byte_ctr);
            bus_addr == A_NBLK: rd_mux = 16'(blk_ctr);
            bus_addr == A_FIFO: rd_mux = fifo_q;
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    // R4: a low-half write leaves the high half alone
    p_arg_halves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_argl && !soft_rst) |=> cmd_arg[31:16] == $past(cmd_arg[31:16]));
    // R5: a command pulse only follows a command write
    p_cmd_follows_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(wr_cmd));
    // R2: with no enabled bits the interrupt stays low
    p_irq_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);
    // R13: read data holds when no read is requested
    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/card_host_regs_tb.sv
module card_host_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        card_det = 1'b0, xfer_byte = 1'b0;
    logic        irq, cmd_valid, cmd_dir;
    logic [5:0]  cmd_index;
    logic [2:0]  cmd_rsp_type;
    logic [1:0]  cmd_kind, cfg_mode;
    logic [31:0] cmd_arg;
    logic        cfg_wide_bus, cfg_enable, cfg_big_endian, rx_dma_en, tx_dma_en;
    logic [9:0]  cfg_clk_div;
    logic [4:0]  fifo_af_level, fifo_ae_level;
    logic [7:0]  cmd_timeout;
    logic [15:0] data_timeout;

    int total = 0, bad = 0;
    logic [15:0] r;

    always #2 clk = ~clk;

    card_host_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .card_det(card_det), .xfer_byte(xfer_byte), .irq(irq),
        .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_rsp_type(cmd_rsp_type),
        .cmd_kind(cmd_kind), .cmd_dir(cmd_dir), .cmd_arg(cmd_arg),
        .cfg_wide_bus(cfg_wide_bus), .cfg_mode(cfg_mode), .cfg_enable(cfg_enable),
        .cfg_big_endian(cfg_big_endian), .cfg_clk_div(cfg_clk_div),
        .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
        .fifo_af_level(fifo_af_level), .fifo_ae_level(fifo_ae_level),
        .cmd_timeout(cmd_timeout), .data_timeout(data_timeout)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_byte();
        @(negedge clk);
        xfer_byte = 1'b1;
        @(negedge clk);
        xfer_byte = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        foreach (r[i]) ; // no-op
        for (int a = 0; a < 'h30; a += 4) begin
            rd(7'(a), r);
            check("R1 reset read", r, (a == 'h2C) ? 16'h1F00 : 16'h0000);
        end
        check("R1 irq low", irq, 0);
        check("R1 af level", fifo_af_level, 5'h1F);

        // R11 card insertion
        @(negedge clk) card_det = 1'b1;
        rd(7'h10, r); check("R11 insert sets bit1", r, 16'h0002);

        // R2 interrupt mask sweep
        for (int b = 0; b < 16; b++) begin
            wr(7'h14, 16'(1 << b));
            check("R2 irq per enable bit", irq, (b == 1));
            rd(7'h14, r); check("R2 enable readback", r, 16'(1 << b) & 16'h7FFF);
        end
        wr(7'h14, 16'h0000);

        // R3 write-one-to-clear
        wr(7'h10, 16'h0000); rd(7'h10, r); check("R3 zero write keeps", r, 16'h0002);
        wr(7'h10, 16'hFFFD); rd(7'h10, r); check("R3 other ones keep", r, 16'h0002);
        wr(7'h10, 16'h0002); rd(7'h10, r); check("R3 one clears", r, 16'h0000);

        // R11 held high does not re-set, new edge does
        repeat (4) @(negedge clk);
        rd(7'h10, r); check("R11 held high no reset", r, 16'h0000);
        @(negedge clk) card_det = 1'b0;
        @(negedge clk) card_det = 1'b1;
        rd(7'h10, r); check("R11 second edge", r, 16'h0002);
        wr(7'h10, 16'h0002);

        // R9 / R10 counters: length 3, count 2
        wr(7'h24, 16'h0002); wr(7'h28, 16'h0001);
        rd(7'h24, r); check("R9 blen stored +1", r, 16'd3);
        rd(7'h28, r); check("R9 nblk stored +1", r, 16'd2);
        for (int k = 1; k <= 7; k++) begin
            pulse_byte();
            rd(7'h24, r); check("R10 byte counter", r, 16'(3 - (k % 3)));
            rd(7'h28, r); check("R10 block counter", r, 16'(2 - ((k / 3) % 2)));
            rd(7'h10, r); check("R10 done bit", r, (k >= 6) ? 16'h0008 : 16'h0000);
        end
        wr(7'h10, 16'h0008);
        rd(7'h10, r); check("R3 done cleared", r, 16'h0000);
        // counters now: byte 2, blk 2 -> 5 more bytes to final, set wins over clear
        repeat (4) pulse_byte();
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 7'h10; bus_wdata = 16'h0008; xfer_byte = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; xfer_byte = 1'b0;
        rd(7'h10, r); check("R3 set wins over clear", r, 16'h0008);
        wr(7'h10, 16'h0008);

        // R9 block-count write reloads byte counter
        pulse_byte();
        rd(7'h24, r); check("R9 byte stepped", r, 16'd2);
        wr(7'h28, 16'h0004);
        rd(7'h24, r); check("R9 nblk write reloads byte", r, 16'd3);
        rd(7'h28, r); check("R9 nblk value", r, 16'd5);
        wr(7'h24, 16'hFFFF);
        rd(7'h24, r); check("R9 max length", r, 16'h0800);

        // R5 command issue
        for (int i = 0; i < 8; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h2493) ^ ((i & 1) != 0 ? 16'h8000 : 16'h0000);
            @(negedge clk);
            bus_we = 1'b1; bus_addr = 7'h00; bus_wdata = v;
            @(negedge clk);
            bus_we = 1'b0;
            check("R5 pulse", cmd_valid, 1);
            check("R5 fields", {cmd_dir, cmd_kind, cmd_rsp_type, cmd_index},
                  {v[15], v[13:12], v[10:8], v[5:0]});
            @(negedge clk);
            check("R5 single cycle", cmd_valid, 0);
            rd(7'h00, r); check("R5 readback", r, v & 16'hB73F);
        end

        // R4 argument halves
        for (int i = 0; i < 4; i++) begin
            logic [15:0] lo, hi;
            lo = 16'(16'h1111 * (i + 1)) ^ 16'hA5A5;
            hi = 16'(16'h0F0F << i);
            wr(7'h08, hi); wr(7'h04, lo);
            check("R4 argument", cmd_arg, {hi, lo});
            wr(7'h04, ~lo);
            check("R4 low write keeps high", cmd_arg, {hi, ~lo});
            rd(7'h08, r); check("R4 high readback", r, hi);
        end

        // R6 / R7 / R8 field sweeps
        for (int i = 0; i < 24; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h1F35) ^ 16'(i << 11);
            wr(7'h0C, v);
            check("R6 fields", {cfg_wide_bus, cfg_mode, cfg_enable, cfg_big_endian, cfg_clk_div},
                  {v[15], v[13:12], v[11], v[10], v[9:0]});
            rd(7'h0C, r); check("R6 readback", r, v & 16'hBFFF);
            wr(7'h2C, v);
            check("R7 fields", {rx_dma_en, fifo_af_level, tx_dma_en, fifo_ae_level},
                  {v[15], v[12:8], v[7], v[4:0]});
            rd(7'h2C, r); check("R7 readback", r, v & 16'h9F9F);
            wr(7'h18, v); wr(7'h1C, ~v);
            check("R8 timeouts", {cmd_timeout, data_timeout}, {v[7:0], ~v});
            rd(7'h18, r); check("R8 cto readback", r, {8'h00, v[7:0]});
        end

        // R13 unmapped and hold
        rd(7'h30, r); check("R13 unmapped", r, 16'h0000);
        rd(7'h1C, r);
        @(negedge clk) bus_addr = 7'h00;
        @(negedge clk) check("R13 hold", bus_rdata, r);

        // R12 soft reset
        wr(7'h64, 16'hFFFB);
        check("R12 bit2 clear no effect", cmd_arg[15:0] != 16'h0, 1);
        wr(7'h64, 16'h0004);
        check("R12 argument cleared", cmd_arg, 0);
        rd(7'h2C, r); check("R12 fifo reg", r, 16'h1F00);
        rd(7'h24, r); check("R12 byte counter", r, 16'h0000);
        rd(7'h0C, r); check("R12 config", r, 16'h0000);
        repeat (3) @(negedge clk);
        rd(7'h10, r); check("R12 card state kept", r, 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule